// File: doc/BRIEF.md
# Multi-Select Bus-Attached Static RAM

A 128-word by 8-bit static memory meant to hang directly off a processor's shared bidirectional data bus. The block sees one byte bus, split here into `bus_in`, `bus_out` and a drive enable `bus_oe`, so that the three-state pad can be built at the chip top. It also takes a 7-bit word address, an active-low read strobe, an active-low write strobe and five select lines. Only one fixed mix of select levels enables the memory, and that lets several of these blocks share a bus without external decode logic.

Everything is synchronous to one clock. A write takes place on the edge where the block is selected and the write strobe is low. A read presents the addressed word after a parameterised access latency. The word is then held on the bus until the read strobe rises, the block is deselected, or the latency has run out after an address change. The address may move while the read strobe stays low, and the old byte stays on the bus until the new one is ready. Memory contents are not reset; reset clears only the read-side state.

Top module: `msel_sram`

## Requirements
- R1: On a rising clock edge where the block is selected and `wr_n` is low, `bus_in` is stored at word `addr`, and any of the 128 words (0 to 127) reads back what was last stored there.
- R2: The block is selected only when `sel[0]`=1, `sel[1]`=0, `sel[2]`=0, `sel[3]`=1 and `sel[4]`=0 all hold at once (pattern 5'b01001); each of the other 31 patterns deselects it.
- R3: While deselected, a low `wr_n` stores nothing: the addressed word keeps its earlier value.
- R4: While deselected, `bus_oe` is low whatever `rd_n` and `wr_n` are doing.
- R5: `bus_oe` is low in any cycle where `rd_n` is high.
- R6: When selected with both `rd_n` and `wr_n` low, `bus_oe` stays low (the bus is never driven); the write itself still takes place.
- R7: A read starts when the block is selected with `rd_n` low and `wr_n` high. `bus_oe` rises and `bus_out` shows the addressed word after ACC_LAT rising edges have sampled that condition, and not before.
- R8: If `addr` changes during a read, `bus_oe` stays high and `bus_out` keeps the old word for ACC_LAT-1 further edges, then shows the new word from the ACC_LAT-th edge that samples the new address.
- R9: After `rd_n` rises or the block is deselected, a new read again waits the full ACC_LAT edges before `bus_oe` rises.
- R10: After reset `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of read-side state |
| addr | input | 7 | Word address |
| sel | input | 5 | Select lines, enabled by pattern 5'b01001 |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Byte taken from the bus for writes |
| bus_out | output | 8 | Byte offered to the bus during reads |
| bus_oe | output | 1 | High when the block should drive the bus |

## Verification
The bench tries all 31 wrong select patterns for both reads and writes. A decoder that inverts one polarity or ignores one line would drive the bus or overwrite the guard word. With a latency of two, it moves the address in the middle of a read: a design that presents new data early, or drops the enable across the change, shows the wrong byte or a released bus in the hold cycle. It also drives both strobes low together, which catches a design that drives the bus during a conflicting write or that drops the write. Rereads after a strobe release and after a deselect expose read-side state that carries over into a stale, early enable.

// File: rtl/msr_pkg.sv
package msr_pkg;
   // Default geometry of the memory
   parameter int unsigned MSR_ADDR_W = 7;
   parameter int unsigned MSR_DATA_W = 8;
   // Number of select lines and the level each must have to enable the block
   parameter int unsigned MSR_NSEL   = 5;
   parameter logic [MSR_NSEL-1:0] MSR_SEL_HI = 5'b01001;
   // Default access latency in clock edges
   parameter int unsigned MSR_ACC_LAT = 1;
endpackage

// File: rtl/msr_sel_dec.sv
module msr_sel_dec #(
   parameter int unsigned        NSEL   = 5,
   parameter logic [NSEL-1:0]    SEL_HI = '0
) (
   input  logic [NSEL-1:0] sel,
   output logic            sel_ok
);
   logic [NSEL-1:0] hit;

   generate
      if (NSEL < 1) begin : g_bad_nsel
         $error("msr_sel_dec: NSEL must be at least 1");
      end
      for (genvar i = 0; i < NSEL; i++) begin : g_line
         if (SEL_HI[i]) begin : g_hi
            assign hit[i] = sel[i];
         end else begin : g_lo
            assign hit[i] = ~sel[i];
         end
      end
   endgenerate

   assign sel_ok = &hit;
endmodule

// File: rtl/msr_store.sv
module msr_store #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
         $error("msr_store: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("msr_store: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

   // R1: a write lands at the sampled address with the sampled data
   a_r1_store: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(addr)] == $past(wdata));

   // R3: with no write enable, the word at a steady address keeps its value
   a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !we ##1 $stable(addr) |-> $stable(rdata));
endmodule

// File: rtl/msr_rd_hold.sv
module msr_rd_hold #(
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ACC_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_active,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] word,
   output logic              valid,
   output logic [DATA_W-1:0] dout
);
   localparam int unsigned CW = $clog2(ACC_LAT + 1);

   generate
      if (ACC_LAT < 1) begin : g_bad_lat
         $error("msr_rd_hold: ACC_LAT must be at least 1");
      end
   endgenerate

   logic [CW-1:0]     age_q, age_nxt;
   logic [ADDR_W-1:0] last_q;
   logic              same, ld, valid_q;
   logic [DATA_W-1:0] dout_q;

   // Same address as the previous active edge of an ongoing read
   assign same = (age_q != '0) && (addr == last_q);

   always_comb begin
      if (!rd_active)                 age_nxt = '0;
      else if (!same)                 age_nxt = CW'(1);
      else if (age_q == CW'(ACC_LAT)) age_nxt = age_q;
      else                            age_nxt = age_q + CW'(1);
   end

   assign ld = rd_active && (age_nxt == CW'(ACC_LAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q   <= '0;
         last_q  <= '0;
         valid_q <= 1'b0;
         dout_q  <= '0;
      end else begin
         age_q   <= age_nxt;
         last_q  <= addr;
         valid_q <= rd_active && (valid_q || ld);
         if (ld) dout_q <= word;
      end
   end

   assign valid = valid_q;
   assign dout  = dout_q;

   // R8: the presented byte only moves on an edge that completes an access
   a_r8_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(dout_q));

   // R9: an edge without an active read leaves no valid data for the next cycle
   a_r9_fresh_wait: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_active |=> !valid_q);
endmodule

// File: rtl/msel_sram.sv
module msel_sram
   import msr_pkg::*;
#(
   parameter int unsigned             ADDR_W  = MSR_ADDR_W,
   parameter int unsigned             DATA_W  = MSR_DATA_W,
   parameter int unsigned             NSEL    = MSR_NSEL,
   parameter logic [MSR_NSEL-1:0]     SEL_HI  = MSR_SEL_HI,
   parameter int unsigned             ACC_LAT = MSR_ACC_LAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NSEL-1:0]   sel,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe
);
   generate
      if (NSEL != MSR_NSEL) begin : g_bad_sel
         $error("msel_sram: NSEL must match the select mask width");
      end
   endgenerate

   logic              sel_ok, we, rd_active, valid;
   logic [DATA_W-1:0] word, dout;

   msr_sel_dec #(.NSEL(NSEL), .SEL_HI(SEL_HI)) u_dec (
      .sel    (sel),
      .sel_ok (sel_ok)
   );

   assign we        = sel_ok && !wr_n;
   assign rd_active = sel_ok && !rd_n && wr_n;

   msr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .addr  (addr),
      .wdata (bus_in),
      .rdata (word)
   );

   msr_rd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_LAT(ACC_LAT)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_active (rd_active),
      .addr      (addr),
      .word      (word),
      .valid     (valid),
      .dout      (dout)
   );

   assign bus_oe  = rd_active && valid;
   assign bus_out = dout;

   // R4: a deselected block never drives the bus
   a_r4_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |-> !bus_oe);

   // R5: a high read strobe releases the bus
   a_r5_rd_high: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> !bus_oe);

   // R6: both strobes low while selected must not drive the bus
   a_r6_conflict: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && !rd_n && !wr_n) |-> !bus_oe);
endmodule

// File: tb/sim_msel_sram.sv
module sim_msel_sram;
   localparam int CLK_P  = 10;
   localparam int LAT    = 2;
   localparam logic [4:0] GOOD = 5'b01001;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] addr = '0;
   logic [4:0] sel = '0;
   logic       rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0] bus_in = '0;
   logic [7:0] bus_out;
   logic       bus_oe;

   int n_run = 0, n_fail = 0;
   logic [7:0] ref_mem [128];

   always #(CLK_P/2) clk = ~clk;

   msel_sram #(.ACC_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .rd_n(rd_n),
      .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      rd_n = 1'b1; wr_n = 1'b1; sel = GOOD;
   endtask

   task automatic wr(input logic [4:0] s, input logic [6:0] a, input logic [7:0] d);
      @(negedge clk);
      sel = s; addr = a; bus_in = d; rd_n = 1'b1; wr_n = 1'b0;
      if (s == GOOD) ref_mem[a] = d;
      @(negedge clk);
      wr_n = 1'b1;
   endtask

   // Full read with latency check; leaves the read active
   task automatic rd_open(input logic [6:0] a, input string req);
      @(negedge clk);
      sel = GOOD; addr = a; rd_n = 1'b0; wr_n = 1'b1;
      #1 chk({req, " oe low at read start"}, {7'd0, bus_oe}, 8'd0);
      for (int i = 0; i < LAT; i++) begin
         @(posedge clk); #1;
         if (i < LAT - 1) chk({req, " oe low inside latency"}, {7'd0, bus_oe}, 8'd0);
      end
      chk({req, " oe high after latency"}, {7'd0, bus_oe}, 8'd1);
      chk({req, " read data"}, bus_out, ref_mem[a]);
   endtask

   task automatic rd(input logic [6:0] a, input string req);
      rd_open(a, req);
      idle();
   endtask

   task automatic t_reset();
      // R10
      sel = GOOD; rd_n = 1'b0;
      #1 chk("R10 oe low in reset", {7'd0, bus_oe}, 8'd0);
      rd_n = 1'b1;
   endtask

   task automatic t_fill();
      // R1 R7: pattern incl. both end words
      for (int a = 0; a < 128; a += 9) wr(GOOD, 7'(a), 8'(a * 29 + 3));
      wr(GOOD, 7'd127, 8'hA7);
      wr(GOOD, 7'd0, 8'h5C);
      rd(7'd0, "R1 word0");
      rd(7'd127, "R1 word127");
      rd(7'd45, "R7 word45");
      wr(GOOD, 7'd45, 8'hC3);
      rd(7'd45, "R1 overwrite");
   endtask

   task automatic t_selects();
      // R2 R3 R4: every wrong pattern
      wr(GOOD, 7'd5, 8'h55);
      for (int s = 0; s < 32; s++) begin
         if (5'(s) != GOOD) begin
            @(negedge clk);
            sel = 5'(s); addr = 7'd5; rd_n = 1'b0; wr_n = 1'b1;
            repeat (LAT + 1) @(posedge clk);
            #1 chk("R4 R2 deselected read oe", {7'd0, bus_oe}, 8'd0);
            rd_n = 1'b1;
            wr(5'(s), 7'd5, 8'hEE);
            @(negedge clk);
            sel = 5'(s); rd_n = 1'b0; wr_n = 1'b0;
            #1 chk("R4 deselected both strobes oe", {7'd0, bus_oe}, 8'd0);
            rd_n = 1'b1; wr_n = 1'b1;
         end
      end
      rd(7'd5, "R3 guard word kept");
   endtask

   task automatic t_addr_change();
      // R8
      wr(GOOD, 7'd20, 8'h21);
      wr(GOOD, 7'd21, 8'h9E);
      rd_open(7'd20, "R8 first");
      @(negedge clk);
      addr = 7'd21;
      #1 chk("R8 old byte after move", bus_out, 8'h21);
      chk("R8 oe kept", {7'd0, bus_oe}, 8'd1);
      for (int i = 0; i < LAT; i++) begin
         @(posedge clk); #1;
         chk("R8 oe across change", {7'd0, bus_oe}, 8'd1);
         chk("R8 byte during hold", bus_out, (i < LAT - 1) ? 8'h21 : 8'h9E);
      end
      idle();
   endtask

   task automatic t_release();
      // R5 R9
      rd_open(7'd127, "R9 base");
      @(negedge clk);
      rd_n = 1'b1;
      #1 chk("R5 rd high releases", {7'd0, bus_oe}, 8'd0);
      rd(7'd127, "R9 after rd high");
      rd_open(7'd0, "R9 base2");
      @(negedge clk);
      sel = 5'b01011;
      #1 chk("R4 deselect mid read", {7'd0, bus_oe}, 8'd0);
      @(posedge clk);
      rd(7'd0, "R9 after deselect");
   endtask

   task automatic t_conflict();
      // R6
      @(negedge clk);
      sel = GOOD; addr = 7'd66; bus_in = 8'h3D; rd_n = 1'b0; wr_n = 1'b0;
      ref_mem[66] = 8'h3D;
      for (int i = 0; i <= LAT; i++) begin
         #1 chk("R6 no drive on conflict", {7'd0, bus_oe}, 8'd0);
         @(negedge clk);
      end
      rd_n = 1'b1; wr_n = 1'b1;
      rd(7'd66, "R6 conflict write stored");
   endtask

   initial begin
      t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_fill();
      t_selects();
      t_addr_change();
      t_release();
      t_conflict();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule